// File: doc/BRIEF.md
# Call Gate Privilege Transfer Sequencer

This block carries out the control-transfer part of a far call made through a call gate. A start pulse brings in four things. The first is the gate's fields: its privilege level, the privilege level of the code segment it targets, the entry offset and a fixed parameter-word count. The second is the caller's current privilege level and stack selector and pointer. The third is the base address of the current task's stack table. The block checks both privilege rules and the parameter count. A call that passes these checks either completes at once, when it stays at the caller's level, or performs a full stack switch, when it moves to a more privileged level.

For a privilege rise, the sequencer reads the target level's stack pointer and stack selector from the task's stack table. It then pushes the caller's stack selector and stack pointer onto the new stack. Next it copies the gate's parameter words from the caller's stack, highest address first. Every transfer goes through a single word-wide memory port with a valid/ready handshake. When the sequence ends, the block pulses `done_o` with the new privilege level, entry offset and stack selector and pointer. If a check fails, it pulses `fault_o` with a cause code and performs no memory access.

Top module: `gate_xfer_seq`

## Requirements
- R1: A caller whose privilege level is numerically greater than the gate's level is refused: `fault_o` pulses with cause 1 and no memory beat occurs. This check takes priority over every other check.
- R2: If the gate check passes and the target level is numerically greater than the caller's level, the call faults with cause 2 and no memory beat occurs.
- R3: If both privilege checks pass and the parameter count exceeds MAX_PARMS (32), the call faults with cause 3. This applies whether or not the call changes level.
- R4: A valid call whose target level equals the caller's level performs no memory beat. `done_o` pulses in the cycle after the start is sampled. The output stack selector and stack pointer equal the caller's.
- R5: On a privilege rise, the new stack pointer is read from word address `tss_base + 8*target_level`. The new selector is the low 16 bits of the word at the next word address. The call makes exactly 2 + count read beats.
- R6: After the stack switch, the first write puts the caller's selector, zero-extended to 32 bits, at `new_sp - 4`. The second write puts the caller's stack pointer at `new_sp - 8`.
- R7: Parameter word k is the word at `caller_sp + 4k`. The words are copied from k = count-1 down to k = 0. Word k lands at `new_sp - 8 - 4*(count-k)`, and no other write occurs.
- R8: At `done_o` the outputs hold the following values: the new privilege level equals the target level, the entry offset equals the gate's offset, and, on a rise, the stack pointer equals `new_sp - 8 - 4*count`. `done_o` and `fault_o` are single-cycle pulses and are never asserted together.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the request, write enable, address and write data hold steady. One word moves on each cycle in which both are high.
- R10: A start pulse that arrives while `busy_o` is high is ignored. The call already in progress completes unchanged.
- R11: During and after reset the block is idle: `busy_o`, `mem_req_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; sampled only while idle |
| cpl_i | input | 2 | Caller's current privilege level |
| gate_dpl_i | input | 2 | Gate privilege level |
| tgt_dpl_i | input | 2 | Privilege level of the target code segment |
| entry_i | input | 32 | Entry offset held in the gate |
| parm_cnt_i | input | 6 | Parameter words to copy |
| ss_i | input | 16 | Caller's stack selector |
| esp_i | input | 32 | Caller's stack pointer |
| tss_base_i | input | 32 | Byte address of the task's stack table |
| mem_req_o | output | 1 | Memory beat request (valid) |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_rdata_i | input | 32 | Read data, valid in the accepting cycle |
| busy_o | output | 1 | A call is in progress |
| done_o | output | 1 | Transfer completed (pulse) |
| fault_o | output | 1 | Call refused (pulse) |
| fault_cause_o | output | 2 | 1 gate, 2 target, 3 count |
| new_cpl_o | output | 2 | Privilege level after the call |
| new_eip_o | output | 32 | Entry offset to execute |
| new_ss_o | output | 16 | Stack selector after the call |
| new_esp_o | output | 32 | Stack pointer after the call |

## Verification
The assertions assume that `mem_rdata_i` is valid in the same cycle as the accepting `mem_ready_i`. They also assume that `mem_ready_i` is raised only toward an outstanding request. The memory responder in the bench sets ready at the falling edge, and only while a request is visible, so no beat is ever accepted without a request. The responder inserts zero to two stall cycles between beats. The bench places the stack table, the caller's stack and each target stack in disjoint regions, so no write can overwrite a word that is read later in the same call.

// File: rtl/gate_xfer_pkg.sv
package gate_xfer_pkg;
  localparam int PL_W = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_GATE   = 2'd1,
    CAUSE_TARGET = 2'd2,
    CAUSE_COUNT  = 2'd3
  } cause_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SP,
    ST_RD_SEL,
    ST_PUSH_SEL,
    ST_PUSH_SP,
    ST_CP_RD,
    ST_CP_WR,
    ST_DONE,
    ST_FAULT
  } state_e;
endpackage

// File: rtl/gate_xfer_chk.sv
module gate_xfer_chk
  import gate_xfer_pkg::*;
#(
  parameter int MAX_PARMS = 32,
  parameter int CNT_W     = 6
) (
  input  logic [PL_W-1:0]  cpl_i,
  input  logic [PL_W-1:0]  gate_dpl_i,
  input  logic [PL_W-1:0]  tgt_dpl_i,
  input  logic [CNT_W-1:0] cnt_i,
  output cause_e           cause_o,
  output logic             raise_o
);
  // gate access first, then target direction, then count
  always_comb begin
    cause_o = CAUSE_NONE;
    if (cpl_i > gate_dpl_i)                 cause_o = CAUSE_GATE;
    else if (tgt_dpl_i > cpl_i)             cause_o = CAUSE_TARGET;
    else if (cnt_i > CNT_W'(MAX_PARMS))     cause_o = CAUSE_COUNT;
  end

  assign raise_o = (tgt_dpl_i < cpl_i);
endmodule

// File: rtl/gate_xfer_ctl.sv
module gate_xfer_ctl
  import gate_xfer_pkg::*;
#(
  parameter int XW    = 32,
  parameter int SW    = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cause_e           cause_i,
  input  logic             raise_i,
  input  logic [PL_W-1:0]  tgt_dpl_i,
  input  logic [XW-1:0]    entry_i,
  input  logic [SW-1:0]    ss_i,
  input  logic [XW-1:0]    esp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [XW-1:0]    tss_base_i,
  input  logic             beat_i,
  input  logic [XW-1:0]    rdata_i,
  output state_e           state_o,
  output cause_e           cause_o,
  output logic [PL_W-1:0]  tgt_o,
  output logic [XW-1:0]    eip_o,
  output logic [SW-1:0]    old_ss_o,
  output logic [XW-1:0]    old_esp_o,
  output logic [SW-1:0]    nss_o,
  output logic [XW-1:0]    nesp_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [XW-1:0]    par_o,
  output logic [XW-1:0]    tss_o
);
  localparam logic [XW-1:0] WORD_B = XW'(4);

  state_e           state_q;
  cause_e           cause_q;
  logic [PL_W-1:0]  tgt_q;
  logic [XW-1:0]    eip_q, old_esp_q, nesp_q, par_q, tss_q;
  logic [SW-1:0]    old_ss_q, nss_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cause_q   <= CAUSE_NONE;
      tgt_q     <= '0;
      eip_q     <= '0;
      old_esp_q <= '0;
      old_ss_q  <= '0;
      nesp_q    <= '0;
      nss_q     <= '0;
      par_q     <= '0;
      tss_q     <= '0;
      cnt_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tgt_q     <= tgt_dpl_i;
          eip_q     <= entry_i;
          old_ss_q  <= ss_i;
          old_esp_q <= esp_i;
          cnt_q     <= cnt_i;
          tss_q     <= tss_base_i;
          cause_q   <= cause_i;
          if (cause_i != CAUSE_NONE) begin
            state_q <= ST_FAULT;
          end else if (raise_i) begin
            state_q <= ST_RD_SP;
          end else begin
            nss_q   <= ss_i;
            nesp_q  <= esp_i;
            state_q <= ST_DONE;
          end
        end
        ST_RD_SP: if (beat_i) begin
          nesp_q  <= rdata_i;
          state_q <= ST_RD_SEL;
        end
        ST_RD_SEL: if (beat_i) begin
          nss_q   <= rdata_i[SW-1:0];
          state_q <= ST_PUSH_SEL;
        end
        ST_PUSH_SEL: if (beat_i) begin
          nesp_q  <= nesp_q - WORD_B;
          state_q <= ST_PUSH_SP;
        end
        ST_PUSH_SP: if (beat_i) begin
          nesp_q  <= nesp_q - WORD_B;
          state_q <= (cnt_q == '0) ? ST_DONE : ST_CP_RD;
        end
        ST_CP_RD: if (beat_i) begin
          par_q   <= rdata_i;
          state_q <= ST_CP_WR;
        end
        ST_CP_WR: if (beat_i) begin
          nesp_q  <= nesp_q - WORD_B;
          cnt_q   <= cnt_q - CNT_W'(1);
          state_q <= (cnt_q == CNT_W'(1)) ? ST_DONE : ST_CP_RD;
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign cause_o   = cause_q;
  assign tgt_o     = tgt_q;
  assign eip_o     = eip_q;
  assign old_ss_o  = old_ss_q;
  assign old_esp_o = old_esp_q;
  assign nss_o     = nss_q;
  assign nesp_o    = nesp_q;
  assign cnt_o     = cnt_q;
  assign par_o     = par_q;
  assign tss_o     = tss_q;
endmodule

// File: rtl/gate_xfer_mport.sv
module gate_xfer_mport
  import gate_xfer_pkg::*;
#(
  parameter int XW    = 32,
  parameter int SW    = 16,
  parameter int CNT_W = 6
) (
  input  state_e           state_i,
  input  logic [PL_W-1:0]  tgt_i,
  input  logic [XW-1:0]    tss_i,
  input  logic [XW-1:0]    nesp_i,
  input  logic [SW-1:0]    old_ss_i,
  input  logic [XW-1:0]    old_esp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [XW-1:0]    par_i,
  output logic             req_o,
  output logic             we_o,
  output logic [XW-1:0]    addr_o,
  output logic [XW-1:0]    wdata_o
);
  localparam logic [XW-1:0] WORD_B = XW'(4);

  logic [XW-1:0] slot_a;
  logic [XW-1:0] push_a;
  logic [XW-1:0] parm_a;

  // table entry per level: pointer word, then selector word
  assign slot_a = tss_i + (XW'(tgt_i) << 3);
  assign push_a = nesp_i - WORD_B;
  assign parm_a = old_esp_i + (XW'(cnt_i) << 2) - WORD_B;

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_RD_SP:    begin req_o = 1'b1; addr_o = slot_a; end
      ST_RD_SEL:   begin req_o = 1'b1; addr_o = slot_a + WORD_B; end
      ST_PUSH_SEL: begin req_o = 1'b1; we_o = 1'b1; addr_o = push_a; wdata_o = XW'(old_ss_i); end
      ST_PUSH_SP:  begin req_o = 1'b1; we_o = 1'b1; addr_o = push_a; wdata_o = old_esp_i; end
      ST_CP_RD:    begin req_o = 1'b1; addr_o = parm_a; end
      ST_CP_WR:    begin req_o = 1'b1; we_o = 1'b1; addr_o = push_a; wdata_o = par_i; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/gate_xfer_seq.sv
module gate_xfer_seq
  import gate_xfer_pkg::*;
#(
  parameter  int XW        = 32,
  parameter  int SW        = 16,
  parameter  int MAX_PARMS = 32,
  localparam int CNT_W     = $clog2(MAX_PARMS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PL_W-1:0]  cpl_i,
  input  logic [PL_W-1:0]  gate_dpl_i,
  input  logic [PL_W-1:0]  tgt_dpl_i,
  input  logic [XW-1:0]    entry_i,
  input  logic [CNT_W-1:0] parm_cnt_i,
  input  logic [SW-1:0]    ss_i,
  input  logic [XW-1:0]    esp_i,
  input  logic [XW-1:0]    tss_base_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XW-1:0]    mem_addr_o,
  output logic [XW-1:0]    mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [XW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [1:0]       fault_cause_o,
  output logic [PL_W-1:0]  new_cpl_o,
  output logic [XW-1:0]    new_eip_o,
  output logic [SW-1:0]    new_ss_o,
  output logic [XW-1:0]    new_esp_o
);
  cause_e           chk_cause, cause_q;
  logic             chk_raise;
  state_e           state;
  logic [PL_W-1:0]  tgt_q;
  logic [XW-1:0]    eip_q, old_esp_q, nesp_q, par_q, tss_q;
  logic [SW-1:0]    old_ss_q, nss_q;
  logic [CNT_W-1:0] cnt_q;
  logic             beat;

  assign beat = mem_req_o && mem_ready_i;

  gate_xfer_chk #(.MAX_PARMS(MAX_PARMS), .CNT_W(CNT_W)) u_chk (
    .cpl_i      (cpl_i),
    .gate_dpl_i (gate_dpl_i),
    .tgt_dpl_i  (tgt_dpl_i),
    .cnt_i      (parm_cnt_i),
    .cause_o    (chk_cause),
    .raise_o    (chk_raise)
  );

  gate_xfer_ctl #(.XW(XW), .SW(SW), .CNT_W(CNT_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cause_i    (chk_cause),
    .raise_i    (chk_raise),
    .tgt_dpl_i  (tgt_dpl_i),
    .entry_i    (entry_i),
    .ss_i       (ss_i),
    .esp_i      (esp_i),
    .cnt_i      (parm_cnt_i),
    .tss_base_i (tss_base_i),
    .beat_i     (beat),
    .rdata_i    (mem_rdata_i),
    .state_o    (state),
    .cause_o    (cause_q),
    .tgt_o      (tgt_q),
    .eip_o      (eip_q),
    .old_ss_o   (old_ss_q),
    .old_esp_o  (old_esp_q),
    .nss_o      (nss_q),
    .nesp_o     (nesp_q),
    .cnt_o      (cnt_q),
    .par_o      (par_q),
    .tss_o      (tss_q)
  );

  gate_xfer_mport #(.XW(XW), .SW(SW), .CNT_W(CNT_W)) u_mport (
    .state_i   (state),
    .tgt_i     (tgt_q),
    .tss_i     (tss_q),
    .nesp_i    (nesp_q),
    .old_ss_i  (old_ss_q),
    .old_esp_i (old_esp_q),
    .cnt_i     (cnt_q),
    .par_i     (par_q),
    .req_o     (mem_req_o),
    .we_o      (mem_we_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o)
  );

  assign busy_o        = (state != ST_IDLE);
  assign done_o        = (state == ST_DONE);
  assign fault_o       = (state == ST_FAULT);
  assign fault_cause_o = cause_q;
  assign new_cpl_o     = tgt_q;
  assign new_eip_o     = eip_q;
  assign new_ss_o      = nss_q;
  assign new_esp_o     = nesp_q;
endmodule

// File: rtl/gate_xfer_seq_chk.sv
module gate_xfer_seq_chk #(
  parameter int XW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [XW-1:0] mem_addr_o,
  input logic [XW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  // R11
  req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  // R1
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !mem_req_o);

  // R8
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fault_o}));

  // R8
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o || fault_o |=> !busy_o);

  // R10
  start_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind gate_xfer_seq gate_xfer_seq_chk #(.XW(XW)) u_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/gate_xfer_seq_tb_top.sv
module gate_xfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 32;
  localparam int SW = 16;
  localparam int CNT_W = 6;
  localparam logic [31:0] TSS_BASE = 32'h0000_0100;
  localparam logic [31:0] OLD_SP   = 32'h0000_0400;
  localparam logic [15:0] OLD_SEL  = 16'h002B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             start_i = 1'b0;
  logic [1:0]       cpl_i = '0, gate_dpl_i = '0, tgt_dpl_i = '0;
  logic [XW-1:0]    entry_i = '0, esp_i = '0, tss_base_i = '0;
  logic [CNT_W-1:0] parm_cnt_i = '0;
  logic [SW-1:0]    ss_i = '0;
  logic             mem_req_o, mem_we_o, mem_ready_i;
  logic [XW-1:0]    mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic             busy_o, done_o, fault_o;
  logic [1:0]       fault_cause_o, new_cpl_o;
  logic [XW-1:0]    new_eip_o, new_esp_o;
  logic [SW-1:0]    new_ss_o;

  gate_xfer_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .cpl_i(cpl_i),
    .gate_dpl_i(gate_dpl_i), .tgt_dpl_i(tgt_dpl_i), .entry_i(entry_i),
    .parm_cnt_i(parm_cnt_i), .ss_i(ss_i), .esp_i(esp_i), .tss_base_i(tss_base_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .fault_cause_o(fault_cause_o),
    .new_cpl_o(new_cpl_o), .new_eip_o(new_eip_o), .new_ss_o(new_ss_o), .new_esp_o(new_esp_o)
  );

  int checks = 0;
  int errors = 0;

  typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t exp_q[$];
  wr_t exp_w;
  logic [31:0] mem [0:1023];
  int rd_beats = 0;
  int wr_idx = 0;
  int stall = 0;
  logic [7:0] lfsr = 8'h5B;
  logic prev_wait = 1'b0;
  logic prev_we = 1'b0;
  logic [31:0] prev_a = '0, prev_d = '0;
  string tag;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and write monitor (scoreboard consumer)
  initial mem_ready_i = 1'b0;
  initial mem_rdata_i = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready_i = 1'b0;
      prev_wait = 1'b0;
    end else begin
      if (prev_wait) begin
        chk("R9 req held", {31'b0, mem_req_o}, 32'd1);
        chk("R9 addr held", mem_addr_o, prev_a);
        chk("R9 data held", mem_wdata_o, prev_d);
        chk("R9 we held", {31'b0, mem_we_o}, {31'b0, prev_we});
      end
      prev_wait = 1'b0;
      if (mem_req_o) begin
        if (stall > 0) begin
          stall--;
          mem_ready_i = 1'b0;
          prev_wait = 1'b1;
          prev_a = mem_addr_o;
          prev_d = mem_wdata_o;
          prev_we = mem_we_o;
        end else begin
          mem_ready_i = 1'b1;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          stall = int'(lfsr[1:0]) % 3;
          if (mem_we_o) begin
            tag = (wr_idx < 2) ? "R6" : "R7";
            if (exp_q.size() == 0) begin
              checks++;
              errors++;
              $display("FAIL %s unexpected write actual=%h expected=none", tag, mem_addr_o);
            end else begin
              exp_w = exp_q.pop_front();
              chk({tag, " write addr"}, mem_addr_o, exp_w.a);
              chk({tag, " write data"}, mem_wdata_o, exp_w.d);
            end
            wr_idx++;
            mem[mem_addr_o[11:2]] = mem_wdata_o;
          end else begin
            mem_rdata_i = mem[mem_addr_o[11:2]];
            rd_beats++;
          end
        end
      end else begin
        mem_ready_i = 1'b0;
      end
    end
  end

  // driver: computes expectations, pushes writes, runs one call
  task automatic do_call(input logic [1:0] cpl, input logic [1:0] gdpl,
                         input logic [1:0] tdpl, input int n, input bit intrude);
    logic [1:0]  cause;
    logic [31:0] nsp, nsel, eip;
    int waited;
    string rq;
    eip = 32'h0000_1000 + 32'(n * 16) + 32'(tdpl);
    if (cpl > gdpl)       begin cause = 2'd1; rq = "R1"; end
    else if (tdpl > cpl)  begin cause = 2'd2; rq = "R2"; end
    else if (n > 32)      begin cause = 2'd3; rq = "R3"; end
    else                  begin cause = 2'd0; rq = "R8"; end
    exp_q.delete();
    rd_beats = 0;
    wr_idx = 0;
    nsp = '0;
    nsel = '0;
    if (cause == 2'd0 && tdpl < cpl) begin
      nsp  = mem[(TSS_BASE >> 2) + 32'(2 * tdpl)];
      nsel = mem[(TSS_BASE >> 2) + 32'(2 * tdpl) + 1];
      exp_q.push_back('{a: nsp - 32'd4, d: {16'h0, OLD_SEL}});
      exp_q.push_back('{a: nsp - 32'd8, d: OLD_SP});
      for (int k = n - 1; k >= 0; k--)
        exp_q.push_back('{a: nsp - 32'd8 - 32'(4 * (n - k)), d: mem[(OLD_SP >> 2) + 32'(k)]});
    end
    @(negedge clk);
    start_i = 1'b1; cpl_i = cpl; gate_dpl_i = gdpl; tgt_dpl_i = tdpl;
    entry_i = eip; parm_cnt_i = CNT_W'(n); ss_i = OLD_SEL; esp_i = OLD_SP;
    tss_base_i = TSS_BASE;
    @(negedge clk);
    start_i = 1'b0;
    waited = 1;
    while (!(done_o || fault_o)) begin
      if (intrude && waited == 3) begin
        start_i = 1'b1; cpl_i = 2'd3; gate_dpl_i = 2'd0; tgt_dpl_i = 2'd3;
        entry_i = 32'hDEAD_0000; esp_i = 32'h0;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start_i = 1'b0;
    if (cause != 2'd0) begin
      chk({rq, " fault"}, {31'b0, fault_o}, 32'd1);
      chk({rq, " cause"}, {30'b0, fault_cause_o}, {30'b0, cause});
      chk({rq, " no reads"}, 32'(rd_beats), 32'd0);
      chk({rq, " no writes"}, 32'(wr_idx), 32'd0);
    end else begin
      chk(intrude ? "R10 done not fault" : "R8 done", {30'b0, fault_o, done_o}, 32'd1);
      chk("R8 cpl", {30'b0, new_cpl_o}, {30'b0, tdpl});
      chk("R8 entry", new_eip_o, eip);
      if (tdpl == cpl) begin
        chk("R4 latency", 32'(waited), 32'd1);
        chk("R4 reads", 32'(rd_beats), 32'd0);
        chk("R4 writes", 32'(wr_idx), 32'd0);
        chk("R4 sel", {16'h0, new_ss_o}, {16'h0, OLD_SEL});
        chk("R4 sp", new_esp_o, OLD_SP);
      end else begin
        chk("R5 reads", 32'(rd_beats), 32'(2 + n));
        chk("R5 sel", {16'h0, new_ss_o}, {16'h0, nsel[15:0]});
        chk("R7 writes", 32'(wr_idx), 32'(2 + n));
        chk("R7 pending", 32'(exp_q.size()), 32'd0);
        chk("R8 sp", new_esp_o, nsp - 32'd8 - 32'(4 * n));
      end
    end
    @(negedge clk);
    chk("R8 pulse", {30'b0, done_o, fault_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hFFFF_0000 + 32'(i);
    mem[(TSS_BASE >> 2) + 0] = 32'h0000_0800;
    mem[(TSS_BASE >> 2) + 1] = 32'hBEEF_0010;
    mem[(TSS_BASE >> 2) + 2] = 32'h0000_0A00;
    mem[(TSS_BASE >> 2) + 3] = 32'hBEEF_0018;
    mem[(TSS_BASE >> 2) + 4] = 32'h0000_0E00;
    mem[(TSS_BASE >> 2) + 5] = 32'hBEEF_0020;
    for (int k = 0; k < 40; k++) mem[(OLD_SP >> 2) + 32'(k)] = 32'hA500_0000 + 32'(k);

    repeat (2) @(negedge clk);
    // R11
    chk("R11 busy", {31'b0, busy_o}, 32'd0);
    chk("R11 req", {31'b0, mem_req_o}, 32'd0);
    chk("R11 done/fault", {30'b0, done_o, fault_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {30'b0, busy_o, mem_req_o}, 32'd0);

    do_call(2'd0, 2'd3, 2'd0, 5, 1'b0);   // R4 same level
    do_call(2'd3, 2'd3, 2'd3, 2, 1'b0);   // R4 same level at ring 3
    do_call(2'd3, 2'd3, 2'd0, 0, 1'b0);   // R5 R6 no parameters
    do_call(2'd3, 2'd3, 2'd0, 3, 1'b0);   // R7
    do_call(2'd2, 2'd2, 2'd1, 32, 1'b0);  // R7 maximum count
    do_call(2'd3, 2'd3, 2'd2, 1, 1'b0);   // R5 level 2 entry
    do_call(2'd3, 2'd2, 2'd0, 1, 1'b0);   // R1
    do_call(2'd3, 2'd1, 2'd3, 40, 1'b0);  // R1 priority over others
    do_call(2'd1, 2'd3, 2'd2, 1, 1'b0);   // R2
    do_call(2'd1, 2'd3, 2'd3, 33, 1'b0);  // R2 priority over count
    do_call(2'd3, 2'd3, 2'd0, 33, 1'b0);  // R3 rise
    do_call(2'd2, 2'd2, 2'd2, 40, 1'b0);  // R3 same level
    do_call(2'd3, 2'd3, 2'd1, 4, 1'b1);   // R10 start during call

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule